// File: doc/BRIEF.md
# Terminal Status Word Register

This block holds the 16-bit status word that a remote terminal on a command/response serial bus returns after each command. It samples the subsystem's condition inputs at fixed moments and sets or clears the flag bits. The terminal address and the service-request flag are loaded when the status word is refreshed for transmission. The message-error and bus-control-acceptance flags are decided when the terminal starts servicing a command, that is, on the rising edge of `in_cmd`. The broadcast flag is loaded whenever a new valid command is decoded.

The block also keeps a latched, active-low terminal-failure output. A continuous self-test failure or a watchdog timeout drives it low. Each status refresh clears it, and the same refresh sets it again if the fault is still present. A third output gives a short active-low enable pulse while the built-in-test word is on the parallel bus. The bit fields of the status word are: [15:11] terminal address, [10] message error, [9] instrumentation, [8] service request, [7:5] reserved, [4] broadcast received, [3] busy, [2] subsystem flag, [1] bus-control acceptance, [0] terminal flag.

Top module: `term_status_word`

## Requirements
- R1: After reset, `status_word` is 16'h0000, `rt_fail_n` is 1 and `bit_en_n` is 1.
- R2: A cycle with `stat_update` high loads `term_addr` into bits [15:11] and sets bit 8 to the inverse of `svc_req_n`, so that a low request gives 1 and a high request gives 0. Both are visible after that clock edge.
- R3: On a rising edge of `in_cmd`, bit 10 takes the value 1 if `illegal_n` is low and 0 if it is high. At any other time, `illegal_n` has no effect.
- R4: On a rising edge of `in_cmd`, bit 1 is set only when all of the following hold: `cmd_is_mode` is 1, `cmd_mode_code` equals the bus-control code (default 5'b00000), `cmd_tr` is 1, `dbc_accept_n` is low and `illegal_n` is high. In every other case, bit 1 becomes 0.
- R5: A cycle with `cmd_valid` high loads `cmd_bcast` into bit 4.
- R6: A cycle with `cmd_valid` high clears bits 10 and 1. If a rising edge of `in_cmd` falls in the same cycle, the values decided at that edge (R3, R4) take priority.
- R7: Bits 9, 7:5, 3, 2 and 0 are always 0.
- R8: If `selftest_fail` or `wdog_timeout` is high in a cycle, `rt_fail_n` is 0 after that clock edge. It stays 0 until a status refresh.
- R9: A cycle with `stat_update` high sets `rt_fail_n` to 1, unless a fault input is high in that same cycle. In that case `rt_fail_n` stays 0.
- R10: A cycle with `bit_word_req` high drives `bit_en_n` low for `BIT_PULSE_CYC` cycles (default 4), starting after that edge. A new request during the pulse restarts the full length.
- R11: Outside the events in R2 to R6, `status_word` holds its value, whatever the condition inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| term_addr | input | 5 | Assigned terminal address |
| svc_req_n | input | 1 | Subsystem service request, active low |
| illegal_n | input | 1 | Illegal-command flag from the subsystem, active low |
| dbc_accept_n | input | 1 | Accept bus control, active low |
| selftest_fail | input | 1 | Continuous self-test failure |
| wdog_timeout | input | 1 | Watchdog timeout event |
| in_cmd | input | 1 | High while a command is being serviced |
| cmd_valid | input | 1 | One-cycle strobe for a new valid command |
| cmd_is_mode | input | 1 | The decoded command is a mode command |
| cmd_mode_code | input | 5 | Mode code field of the command |
| cmd_tr | input | 1 | Transmit/receive bit of the command |
| cmd_bcast | input | 1 | The command was addressed as broadcast |
| stat_update | input | 1 | Status refresh strobe for transmission |
| bit_word_req | input | 1 | Built-in-test word placed on the parallel bus |
| status_word | output | 16 | Assembled status word |
| rt_fail_n | output | 1 | Latched terminal failure, active low |
| bit_en_n | output | 1 | Built-in-test word enable pulse, active low |

## Verification
The bench raises `in_cmd` and `cmd_valid` in the same cycle to check that the values sampled at the edge beat the clear. A design with the wrong priority would show message error or bus-control acceptance as 0 right after an illegal or accepted command. It holds `illegal_n` low while `in_cmd` is steady, or falling, to catch a level-sampled flag that sets message error with no edge. It sends bus-control candidates with the wrong code, with T/R set to 0, with accept not asserted and with an illegal flag; a loose decode would grant acceptance in one of these cases. It also applies a status refresh while a fault is still present, where a plain clear would release `rt_fail_n` for one cycle, and it restarts the test-word pulse partway through, where a design that does not restart would end the pulse too soon.

// File: rtl/sts_pkg.sv
package sts_pkg;
  localparam int STS_W   = 16;
  localparam int TADDR_W = 5;
  localparam int MCODE_W = 5;

  typedef struct packed {
    logic [TADDR_W-1:0] taddr;
    logic               msg_err;
    logic               instr;
    logic               svc_req;
    logic [2:0]         rsvd;
    logic               bcast_rx;
    logic               busy;
    logic               ssf;
    logic               dbca;
    logic               tflag;
  } sts_word_t;

  // Bus-control acceptance qualifier: mode command, matching code, T/R = 1.
  function automatic logic is_dbc_cmd(input logic is_mode,
                                      input logic [MCODE_W-1:0] code,
                                      input logic tr,
                                      input logic [MCODE_W-1:0] dbc_code);
    return is_mode && (code == dbc_code) && tr;
  endfunction

  // Packs the live flags into the transmitted layout; unowned bits read 0.
  function automatic logic [STS_W-1:0] pack_word(input logic [TADDR_W-1:0] taddr,
                                                 input logic msg_err,
                                                 input logic svc_req,
                                                 input logic bcast_rx,
                                                 input logic dbca);
    sts_word_t w;
    w          = '0;
    w.taddr    = taddr;
    w.msg_err  = msg_err;
    w.svc_req  = svc_req;
    w.bcast_rx = bcast_rx;
    w.dbca     = dbca;
    return w;
  endfunction
endpackage

// File: rtl/sts_cmd_sampler.sv
module sts_cmd_sampler
  import sts_pkg::*;
#(
  parameter logic [MCODE_W-1:0] DBC_CODE = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_cmd,
  input  logic               illegal_n,
  input  logic               dbc_accept_n,
  input  logic               cmd_is_mode,
  input  logic [MCODE_W-1:0] cmd_mode_code,
  input  logic               cmd_tr,
  output logic               in_cmd_rise,
  output logic               illegal_hit,
  output logic               dbc_grant
);
  logic in_cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_cmd_q <= 1'b0;
    else        in_cmd_q <= in_cmd;
  end

  assign in_cmd_rise = in_cmd && !in_cmd_q;
  assign illegal_hit = !illegal_n;
  assign dbc_grant   = is_dbc_cmd(cmd_is_mode, cmd_mode_code, cmd_tr, DBC_CODE)
                       && !dbc_accept_n && illegal_n;
endmodule

// File: rtl/sts_flag_bank.sv
module sts_flag_bank
  import sts_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stat_update,
  input  logic               svc_req_n,
  input  logic [TADDR_W-1:0] term_addr,
  input  logic               cmd_valid,
  input  logic               cmd_bcast,
  input  logic               in_cmd_rise,
  input  logic               illegal_hit,
  input  logic               dbc_grant,
  output logic [STS_W-1:0]   word
);
  logic [TADDR_W-1:0] taddr_q;
  logic               svc_q;
  logic               merr_q;
  logic               bcast_q;
  logic               dbca_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taddr_q <= '0;
      svc_q   <= 1'b0;
    end else if (stat_update) begin
      taddr_q <= term_addr;
      svc_q   <= !svc_req_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      merr_q  <= 1'b0;
      dbca_q  <= 1'b0;
      bcast_q <= 1'b0;
    end else begin
      if (cmd_valid) begin
        merr_q  <= 1'b0;
        dbca_q  <= 1'b0;
        bcast_q <= cmd_bcast;
      end
      if (in_cmd_rise) begin
        merr_q <= illegal_hit;
        dbca_q <= dbc_grant;
      end
    end
  end

  assign word = pack_word(taddr_q, merr_q, svc_q, bcast_q, dbca_q);
endmodule

// File: rtl/sts_fail_latch.sv
module sts_fail_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic fault,
  input  logic refresh,
  output logic fail_n
);
  logic fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fail_q <= 1'b0;
    else if (refresh) fail_q <= fault;
    else if (fault)   fail_q <= 1'b1;
  end

  assign fail_n = !fail_q;
endmodule

// File: rtl/sts_bit_pulse.sv
module sts_bit_pulse #(
  parameter int PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic en_n
);
  generate
    if (PULSE_CYC <= 1) begin : g_single
      logic on_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) on_q <= 1'b0;
        else        on_q <= req;
      end
      assign en_n = !on_q;
    end else begin : g_count
      localparam int CNT_W = $clog2(PULSE_CYC + 1);
      localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYC);
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt_q <= '0;
        else if (req)         cnt_q <= LOAD;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end
      assign en_n = (cnt_q == '0);
    end
  endgenerate
endmodule

// File: rtl/term_status_word.sv
module term_status_word
  import sts_pkg::*;
#(
  parameter logic [MCODE_W-1:0] DBC_MODE_CODE = '0,
  parameter int                 BIT_PULSE_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TADDR_W-1:0] term_addr,
  input  logic               svc_req_n,
  input  logic               illegal_n,
  input  logic               dbc_accept_n,
  input  logic               selftest_fail,
  input  logic               wdog_timeout,
  input  logic               in_cmd,
  input  logic               cmd_valid,
  input  logic               cmd_is_mode,
  input  logic [MCODE_W-1:0] cmd_mode_code,
  input  logic               cmd_tr,
  input  logic               cmd_bcast,
  input  logic               stat_update,
  input  logic               bit_word_req,
  output logic [STS_W-1:0]   status_word,
  output logic               rt_fail_n,
  output logic               bit_en_n
);
  logic in_cmd_rise;
  logic illegal_hit;
  logic dbc_grant;
  logic fault_any;

  assign fault_any = selftest_fail || wdog_timeout;

  sts_cmd_sampler #(.DBC_CODE(DBC_MODE_CODE)) u_smp (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_cmd        (in_cmd),
    .illegal_n     (illegal_n),
    .dbc_accept_n  (dbc_accept_n),
    .cmd_is_mode   (cmd_is_mode),
    .cmd_mode_code (cmd_mode_code),
    .cmd_tr        (cmd_tr),
    .in_cmd_rise   (in_cmd_rise),
    .illegal_hit   (illegal_hit),
    .dbc_grant     (dbc_grant)
  );

  sts_flag_bank u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .stat_update (stat_update),
    .svc_req_n   (svc_req_n),
    .term_addr   (term_addr),
    .cmd_valid   (cmd_valid),
    .cmd_bcast   (cmd_bcast),
    .in_cmd_rise (in_cmd_rise),
    .illegal_hit (illegal_hit),
    .dbc_grant   (dbc_grant),
    .word        (status_word)
  );

  sts_fail_latch u_fail (
    .clk     (clk),
    .rst_n   (rst_n),
    .fault   (fault_any),
    .refresh (stat_update),
    .fail_n  (rt_fail_n)
  );

  sts_bit_pulse #(.PULSE_CYC(BIT_PULSE_CYC)) u_bit (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (bit_word_req),
    .en_n  (bit_en_n)
  );
endmodule

// File: rtl/sts_checker.sv
module sts_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        stat_update,
  input logic        svc_req_n,
  input logic        illegal_n,
  input logic        cmd_valid,
  input logic        cmd_bcast,
  input logic        in_cmd_rise,
  input logic        dbc_grant,
  input logic        fault_any,
  input logic        bit_word_req,
  input logic [15:0] status_word,
  input logic        rt_fail_n,
  input logic        bit_en_n
);
  a_r2_svc_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
    stat_update |=> (status_word[8] == !$past(svc_req_n)));

  a_r3_msg_err_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cmd_rise && !illegal_n) |=> status_word[10]);

  a_r4_dbca_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_word[1]) |-> $past(in_cmd_rise && dbc_grant));

  a_r5_bcast_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (status_word[4] == $past(cmd_bcast)));

  a_r7_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[9] == 1'b0) && (status_word[7:5] == 3'b000)
    && (status_word[3:2] == 2'b00) && (status_word[0] == 1'b0));

  a_r8_fault_sets_fail: assert property (@(posedge clk) disable iff (!rst_n)
    fault_any |=> !rt_fail_n);

  a_r9_refresh_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_update && !fault_any) |=> rt_fail_n);

  a_r8_fail_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!rt_fail_n && !stat_update) |=> !rt_fail_n);

  a_r10_pulse_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bit_en_n) |-> $past(bit_word_req));

  a_r11_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_update && !cmd_valid && !in_cmd_rise) |=> $stable(status_word));
endmodule

bind term_status_word sts_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stat_update  (stat_update),
  .svc_req_n    (svc_req_n),
  .illegal_n    (illegal_n),
  .cmd_valid    (cmd_valid),
  .cmd_bcast    (cmd_bcast),
  .in_cmd_rise  (in_cmd_rise),
  .dbc_grant    (dbc_grant),
  .fault_any    (fault_any),
  .bit_word_req (bit_word_req),
  .status_word  (status_word),
  .rt_fail_n    (rt_fail_n),
  .bit_en_n     (bit_en_n)
);

// File: tb/sim_term_status_word.sv
module sim_term_status_word;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  // [34] upd [33] svc_n [32:28] addr [27] cvalid [26] in_cmd [25] ill_n
  // [24] acc_n [23] mode [22:18] code [17] tr [16] bcast [15:0] expected word
  localparam logic [34:0] VEC [NVEC] = '{
    {1'b1,1'b0,5'd22,1'b0,1'b0,1'b1,1'b1,1'b0,5'd0,1'b0,1'b0,16'hB100}, // R2
    {1'b0,1'b1,5'd0 ,1'b1,1'b1,1'b0,1'b1,1'b0,5'd0,1'b0,1'b0,16'hB500}, // R3 R6
    {1'b0,1'b1,5'd0 ,1'b0,1'b1,1'b1,1'b1,1'b0,5'd0,1'b0,1'b0,16'hB500}, // R3 R11
    {1'b0,1'b1,5'd0 ,1'b0,1'b0,1'b0,1'b1,1'b0,5'd0,1'b0,1'b0,16'hB500}, // R3 R11
    {1'b0,1'b1,5'd0 ,1'b1,1'b1,1'b1,1'b0,1'b1,5'd0,1'b1,1'b0,16'hB102}, // R4 R6
    {1'b1,1'b1,5'd3 ,1'b0,1'b0,1'b1,1'b1,1'b0,5'd0,1'b0,1'b0,16'h1802}, // R2
    {1'b0,1'b1,5'd0 ,1'b1,1'b1,1'b1,1'b0,1'b1,5'd0,1'b0,1'b1,16'h1810}, // R4 R5
    {1'b0,1'b1,5'd0 ,1'b1,1'b0,1'b1,1'b1,1'b0,5'd0,1'b0,1'b0,16'h1800}, // R5 R6
    {1'b0,1'b1,5'd0 ,1'b1,1'b1,1'b0,1'b0,1'b1,5'd0,1'b1,1'b1,16'h1C10}, // R3 R4
    {1'b0,1'b1,5'd0 ,1'b0,1'b0,1'b1,1'b1,1'b0,5'd0,1'b0,1'b0,16'h1C10}, // R11
    {1'b0,1'b1,5'd0 ,1'b1,1'b1,1'b1,1'b0,1'b1,5'd1,1'b1,1'b0,16'h1800}, // R4
    {1'b1,1'b0,5'd31,1'b0,1'b0,1'b1,1'b1,1'b0,5'd0,1'b0,1'b0,16'hF900}, // R2
    {1'b0,1'b1,5'd0 ,1'b1,1'b1,1'b1,1'b1,1'b1,5'd0,1'b1,1'b0,16'hF900}, // R4
    {1'b0,1'b1,5'd0 ,1'b0,1'b0,1'b1,1'b1,1'b0,5'd0,1'b0,1'b0,16'hF900}  // R11
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  term_addr = '0;
  logic        svc_req_n = 1'b1, illegal_n = 1'b1, dbc_accept_n = 1'b1;
  logic        selftest_fail = 1'b0, wdog_timeout = 1'b0;
  logic        in_cmd = 1'b0, cmd_valid = 1'b0, cmd_is_mode = 1'b0;
  logic [4:0]  cmd_mode_code = '0;
  logic        cmd_tr = 1'b0, cmd_bcast = 1'b0, stat_update = 1'b0, bit_word_req = 1'b0;
  logic [15:0] status_word;
  logic        rt_fail_n, bit_en_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  term_status_word u0 (
    .clk(clk), .rst_n(rst_n), .term_addr(term_addr), .svc_req_n(svc_req_n),
    .illegal_n(illegal_n), .dbc_accept_n(dbc_accept_n),
    .selftest_fail(selftest_fail), .wdog_timeout(wdog_timeout),
    .in_cmd(in_cmd), .cmd_valid(cmd_valid), .cmd_is_mode(cmd_is_mode),
    .cmd_mode_code(cmd_mode_code), .cmd_tr(cmd_tr), .cmd_bcast(cmd_bcast),
    .stat_update(stat_update), .bit_word_req(bit_word_req),
    .status_word(status_word), .rt_fail_n(rt_fail_n), .bit_en_n(bit_en_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // advance one clock; return at the following falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int low_cnt;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 word", 32'(status_word), 32'h0);
    chk("R1 fail", 32'(rt_fail_n), 32'h1);
    chk("R1 bit_en", 32'(bit_en_n), 32'h1);
    rst_n = 1'b1;
    step();

    // vector table: R2 R3 R4 R5 R6 R7 R11
    for (int i = 0; i < NVEC; i++) begin
      stat_update   = VEC[i][34];
      svc_req_n     = VEC[i][33];
      term_addr     = VEC[i][32:28];
      cmd_valid     = VEC[i][27];
      in_cmd        = VEC[i][26];
      illegal_n     = VEC[i][25];
      dbc_accept_n  = VEC[i][24];
      cmd_is_mode   = VEC[i][23];
      cmd_mode_code = VEC[i][22:18];
      cmd_tr        = VEC[i][17];
      cmd_bcast     = VEC[i][16];
      step();
      chk($sformatf("R2/R3/R4/R5/R6/R11 vector %0d", i), 32'(status_word), 32'(VEC[i][15:0]));
      chk("R7 fixed zero bits", 32'(status_word & 16'h02ED), 32'h0);
    end
    stat_update = 1'b0; cmd_valid = 1'b0; in_cmd = 1'b0; illegal_n = 1'b1;
    dbc_accept_n = 1'b1; cmd_is_mode = 1'b0;

    // R11: service request moves without refresh
    svc_req_n = 1'b1;
    step(); step();
    chk("R11 svc ignored", 32'(status_word[8]), 32'h1);

    // R8 fault latch
    selftest_fail = 1'b1;
    step();
    chk("R8 self-test sets", 32'(rt_fail_n), 32'h0);
    selftest_fail = 1'b0;
    step(); step();
    chk("R8 held", 32'(rt_fail_n), 32'h0);
    // R9 refresh clears
    stat_update = 1'b1;
    step();
    stat_update = 1'b0;
    chk("R9 cleared", 32'(rt_fail_n), 32'h1);
    // R9 refresh with fault still present
    wdog_timeout = 1'b1;
    step();
    chk("R8 watchdog sets", 32'(rt_fail_n), 32'h0);
    stat_update = 1'b1;
    step();
    stat_update = 1'b0;
    wdog_timeout = 1'b0;
    chk("R9 fault persists", 32'(rt_fail_n), 32'h0);
    step();
    chk("R9 still held", 32'(rt_fail_n), 32'h0);

    // R10 single pulse
    bit_word_req = 1'b1;
    step();
    bit_word_req = 1'b0;
    low_cnt = 0;
    for (int k = 0; k < 8; k++) begin
      if (!bit_en_n) low_cnt++;
      step();
    end
    chk("R10 pulse length", 32'(low_cnt), 32'd4);
    // R10 restart mid-pulse
    bit_word_req = 1'b1;
    step();
    low_cnt = 0;
    if (!bit_en_n) low_cnt++;
    step();
    bit_word_req = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (!bit_en_n) low_cnt++;
      step();
    end
    chk("R10 restart length", 32'(low_cnt), 32'd5);
    chk("R10 idle high", 32'(bit_en_n), 32'h1);

    finish_run();
  end
endmodule